// File: doc/BRIEF.md
# Transition-Limiting Inverting Bus Lane

This block carries one byte-wide lane over nine wires: eight data wires and one inversion wire. The transmit side remembers the word it last put on all nine wires. For every new byte it counts how many wires would change if the byte went out as it is. That count includes the inversion wire, which would fall if it is currently high. When more than half the data width would switch, the transmit side drives the bitwise complement and raises the inversion wire. Either way, no transfer switches more than four of the nine wires. Without this scheme the worst case is eight.

The receive side takes the nine wires and a valid strobe. It rebuilds the byte by complementing the data wires whenever the inversion wire is high. Both sides are registered and each adds one clock of latency. Cycles with no valid input leave the wires and the stored state untouched. A link is formed by connecting the transmit wires of one instance to the receive inputs of another, or to its own receive inputs for loopback.

Top module: `toggle_limit_lane`

## Requirements
- R1: While reset is asserted and right after it is released, tx_data is 0x00, tx_inv is 0, tx_strobe is 0, rx_data is 0x00 and rx_strobe is 0.
- R2: A byte accepted with in_valid high at a rising edge appears on tx_data/tx_inv right after that edge. tx_strobe is high for exactly that one cycle for each accepted byte.
- R3: In a cycle with in_valid low, tx_data and tx_inv keep their values and tx_strobe is 0, whatever in_data carries.
- R4: Let N be the number of tx_data bits that differ from the new byte, plus 1 if tx_inv is currently 1. If N > 4, the transmit side drives the complement of the byte with tx_inv = 1. Otherwise it drives the byte unchanged with tx_inv = 0. For example, from reset 0x0F goes out plain, while 0x1F goes out as 0xE0 with tx_inv = 1.
- R5: On every transfer, the number of the nine wires {tx_data, tx_inv} that change value is at most 4.
- R6: From reset, sending 0x05 and then 0xFE drives 0x05 (tx_inv 0) and then 0x01 with tx_inv 1. The second transfer switches exactly 2 wires.
- R7: A receive transfer with rx_valid high yields, one cycle later, rx_data equal to rx_wire_data when rx_wire_inv is 0, and equal to its bitwise complement when rx_wire_inv is 1. rx_strobe is high for that one cycle.
- R8: In cycles with rx_valid low, rx_data holds and rx_strobe is 0, whatever rx_wire_data and rx_wire_inv carry.
- R9: Feeding the transmit wires back into the receive inputs returns every sent byte unchanged. This includes a byte that matches the stored data while tx_inv is high: after 0xFE (driven as 0x01, tx_inv 1), the byte 0x01 goes out plain with only the inversion wire switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New byte present on in_data |
| in_data | input | 8 | Byte to transmit |
| tx_data | output | 8 | Registered data wires |
| tx_inv | output | 1 | Registered inversion wire |
| tx_strobe | output | 1 | High for the cycle after a byte is accepted |
| rx_valid | input | 1 | Receive wires carry a transfer |
| rx_wire_data | input | 8 | Received data wires |
| rx_wire_inv | input | 1 | Received inversion wire |
| rx_data | output | 8 | Restored byte, registered |
| rx_strobe | output | 1 | High for the cycle after a receive transfer |

## Verification
The bench builds the lane with its default width of eight data wires. At that width the count of switching wires ranges from 0 to 9, so the threshold at 4 versus 5 can be hit exactly from a known state. Directed sequences that start from reset place the lane on both sides of that threshold. They also cover the case where the only switching wire is the falling inversion wire, and they alternate 0x00 and 0xFF. A long pseudo-random stream, looped back through the receive side, exercises the remaining mix of stored states and incoming bytes.

// File: rtl/tll_pkg.sv
package tll_pkg;

    typedef enum logic {
        DRIVE_PLAIN    = 1'b0,
        DRIVE_INVERTED = 1'b1
    } drive_mode_e;

    function automatic int tll_count_w(input int lane_w);
        return $clog2(lane_w + 2);
    endfunction

endpackage

// File: rtl/tll_popcount.sv
module tll_popcount #(
    parameter int IN_W  = 8,
    parameter int CNT_W = 4
) (
    input  logic [IN_W-1:0]  vec,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] part [IN_W+1];

    assign part[0] = '0;

    for (genvar g = 0; g < IN_W; g++) begin : g_sum
        assign part[g+1] = part[g] + CNT_W'(vec[g]);
    end

    assign count = part[IN_W];

endmodule

// File: rtl/tll_encoder.sv
module tll_encoder
    import tll_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] in_data,
    output logic [LANE_W-1:0] wire_data,
    output logic              wire_inv,
    output logic              strobe
);

    localparam int HALF  = LANE_W / 2;
    localparam int CNT_W = tll_count_w(LANE_W);

    typedef struct packed {
        logic [LANE_W-1:0] data;
        logic              inv;
        logic              strobe;
    } enc_state_t;

    enc_state_t        st_d, st_q;
    logic [CNT_W-1:0]  diff_cnt;
    logic [CNT_W-1:0]  plain_cnt;
    drive_mode_e       mode;

    tll_popcount #(
        .IN_W  (LANE_W),
        .CNT_W (CNT_W)
    ) u_diff (
        .vec   (in_data ^ st_q.data),
        .count (diff_cnt)
    );

    always_comb begin
        plain_cnt = diff_cnt + CNT_W'(st_q.inv);
        mode      = (plain_cnt > CNT_W'(HALF)) ? DRIVE_INVERTED : DRIVE_PLAIN;
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (in_valid) begin
            st_d.strobe = 1'b1;
            if (mode == DRIVE_INVERTED) begin
                st_d.data = ~in_data;
                st_d.inv  = 1'b1;
            end else begin
                st_d.data = in_data;
                st_d.inv  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wire_data = st_q.data;
    assign wire_inv  = st_q.inv;
    assign strobe    = st_q.strobe;

    // R2: one strobe per accepted byte, one cycle later
    a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        strobe == $past(in_valid));

    // R3: idle cycles leave the wires alone
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(wire_data) && $stable(wire_inv)));

    // R4: the driven word decodes back to the accepted byte
    a_r4_payload_recoverable: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> ((wire_data ^ {LANE_W{wire_inv}}) == $past(in_data)));

    // R5: switching across all wires never exceeds half the data width
    a_r5_toggle_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |->
            ($countones({wire_data, wire_inv} ^ {$past(wire_data), $past(wire_inv)}) <= HALF));

endmodule

// File: rtl/tll_decoder.sv
module tll_decoder #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] wire_data,
    input  logic              wire_inv,
    output logic [LANE_W-1:0] out_data,
    output logic              strobe
);

    typedef struct packed {
        logic [LANE_W-1:0] data;
        logic              strobe;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = in_valid;
        if (in_valid) begin
            st_d.data = wire_inv ? ~wire_data : wire_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.data;
    assign strobe   = st_q.strobe;

    // R7: restored byte matches the wires, complemented when flagged
    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) |-> (strobe && (out_data == ($past(wire_data) ^ {LANE_W{$past(wire_inv)}}))));

    // R8: no receive transfer, no change
    a_r8_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!strobe && $stable(out_data)));

endmodule

// File: rtl/toggle_limit_lane.sv
module toggle_limit_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LANE_W-1:0] in_data,
    output logic [LANE_W-1:0] tx_data,
    output logic              tx_inv,
    output logic              tx_strobe,
    input  logic              rx_valid,
    input  logic [LANE_W-1:0] rx_wire_data,
    input  logic              rx_wire_inv,
    output logic [LANE_W-1:0] rx_data,
    output logic              rx_strobe
);

    tll_encoder #(
        .LANE_W (LANE_W)
    ) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wire_data (tx_data),
        .wire_inv  (tx_inv),
        .strobe    (tx_strobe)
    );

    tll_decoder #(
        .LANE_W (LANE_W)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .wire_data (rx_wire_data),
        .wire_inv  (rx_wire_inv),
        .out_data  (rx_data),
        .strobe    (rx_strobe)
    );

    // R1: everything quiet straight out of reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (tx_data == '0 && !tx_inv && !tx_strobe && rx_data == '0 && !rx_strobe));

endmodule

// File: tb/toggle_limit_lane_bench.sv
module toggle_limit_lane_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [7:0] in_data;
    logic [7:0] tx_data;
    logic       tx_inv;
    logic       tx_strobe;
    logic       rx_valid;
    logic [7:0] rx_wire_data;
    logic       rx_wire_inv;
    logic [7:0] rx_data;
    logic       rx_strobe;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 1'b0;

    logic [7:0] m_data;
    logic       m_inv;

    always #(CLK_PERIOD/2) clk = ~clk;

    toggle_limit_lane #(.LANE_W(8)) u_toggle_limit_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .tx_data      (tx_data),
        .tx_inv       (tx_inv),
        .tx_strobe    (tx_strobe),
        .rx_valid     (rx_valid),
        .rx_wire_data (rx_wire_data),
        .rx_wire_inv  (rx_wire_inv),
        .rx_data      (rx_data),
        .rx_strobe    (rx_strobe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        rx_valid = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        m_data = 8'h00;
        m_inv  = 1'b0;
    endtask

    // sends one byte, checks wires against the model, loops them back
    task automatic send_byte(input logic [7:0] b, input string req);
        int         n;
        logic [7:0] e_d;
        logic       e_i;
        logic [8:0] prev;
        int         tog;
        n = $countones(b ^ m_data) + int'(m_inv);
        if (n > 4) begin
            e_d = ~b;
            e_i = 1'b1;
        end else begin
            e_d = b;
            e_i = 1'b0;
        end
        prev = {tx_data, tx_inv};
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~b;
        check(tx_strobe == 1'b1, "R2", "tx_strobe", int'(tx_strobe), 1);
        check(tx_data == e_d, req, "tx_data", int'(tx_data), int'(e_d));
        check(tx_inv == e_i, req, "tx_inv", int'(tx_inv), int'(e_i));
        tog = $countones(prev ^ {tx_data, tx_inv});
        check(tog <= 4, "R5", "toggles", tog, 4);
        m_data = e_d;
        m_inv  = e_i;
        rx_wire_data = tx_data;
        rx_wire_inv  = tx_inv;
        rx_valid     = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check(tx_strobe == 1'b0, "R2", "tx_strobe after one cycle", int'(tx_strobe), 0);
        check(rx_strobe == 1'b1, "R7", "rx_strobe", int'(rx_strobe), 1);
        check(rx_data == b, "R9", "loopback byte", int'(rx_data), int'(b));
    endtask

    task automatic t_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = 8'hA5;
        rx_valid = 1'b0;
        rx_wire_data = 8'h5A;
        rx_wire_inv  = 1'b1;
        repeat (3) @(negedge clk);
        check(tx_data == 8'h00 && !tx_inv && !tx_strobe, "R1", "tx in reset",
              int'({tx_data, tx_inv, tx_strobe}), 0);
        check(rx_data == 8'h00 && !rx_strobe, "R1", "rx in reset",
              int'({rx_data, rx_strobe}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_data == 8'h00 && !tx_inv && !tx_strobe, "R1", "tx after release",
              int'({tx_data, tx_inv, tx_strobe}), 0);
        m_data = 8'h00;
        m_inv  = 1'b0;
    endtask

    task automatic t_example();
        logic [8:0] prev;
        int         tog;
        apply_reset();
        send_byte(8'h05, "R6");
        check(tx_data == 8'h05 && !tx_inv, "R6", "first word",
              int'({tx_data, tx_inv}), int'({8'h05, 1'b0}));
        prev = {tx_data, tx_inv};
        send_byte(8'hFE, "R6");
        check(tx_data == 8'h01 && tx_inv, "R6", "second word",
              int'({tx_data, tx_inv}), int'({8'h01, 1'b1}));
        tog = $countones(prev ^ {tx_data, tx_inv});
        check(tog == 2, "R6", "second toggles", tog, 2);
    endtask

    task automatic t_threshold();
        apply_reset();
        send_byte(8'h0F, "R4");
        check(tx_data == 8'h0F && !tx_inv, "R4", "four changes plain",
              int'({tx_data, tx_inv}), int'({8'h0F, 1'b0}));
        apply_reset();
        send_byte(8'h1F, "R4");
        check(tx_data == 8'hE0 && tx_inv, "R4", "five changes inverted",
              int'({tx_data, tx_inv}), int'({8'hE0, 1'b1}));
        // stored E0/1: 0xE0 again counts 0 data + 1 flag -> plain
        send_byte(8'hE0, "R4");
        check(tx_data == 8'hE0 && !tx_inv, "R4", "flag-only change plain",
              int'({tx_data, tx_inv}), int'({8'hE0, 1'b0}));
    endtask

    task automatic t_flag_corner();
        logic [8:0] prev;
        int         tog;
        apply_reset();
        send_byte(8'hFE, "R4");
        send_byte(8'hFE, "R4");
        check(tx_data == 8'h01 && tx_inv, "R4", "repeat inverted",
              int'({tx_data, tx_inv}), int'({8'h01, 1'b1}));
        prev = {tx_data, tx_inv};
        send_byte(8'h01, "R9");
        check(tx_data == 8'h01 && !tx_inv, "R9", "flag drop only",
              int'({tx_data, tx_inv}), int'({8'h01, 1'b0}));
        tog = $countones(prev ^ {tx_data, tx_inv});
        check(tog == 1, "R9", "one wire switched", tog, 1);
    endtask

    task automatic t_idle_hold();
        logic [7:0] kd;
        logic       ki;
        logic [7:0] kr;
        apply_reset();
        send_byte(8'h3C, "R4");
        kd = tx_data;
        ki = tx_inv;
        kr = rx_data;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_data      = 8'h11 * i[7:0];
            rx_wire_data = 8'hF0 ^ i[7:0];
            rx_wire_inv  = i[0];
        end
        @(negedge clk);
        check(tx_data == kd && tx_inv == ki && !tx_strobe, "R3", "wires idle",
              int'({tx_data, tx_inv, tx_strobe}), int'({kd, ki, 1'b0}));
        check(rx_data == kr && !rx_strobe, "R8", "rx idle",
              int'({rx_data, rx_strobe}), int'({kr, 1'b0}));
    endtask

    task automatic t_decoder_direct();
        @(negedge clk);
        rx_wire_data = 8'h3C;
        rx_wire_inv  = 1'b1;
        rx_valid     = 1'b1;
        @(negedge clk);
        check(rx_data == 8'hC3 && rx_strobe, "R7", "flagged restore",
              int'({rx_data, rx_strobe}), int'({8'hC3, 1'b1}));
        rx_wire_data = 8'h96;
        rx_wire_inv  = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0;
        check(rx_data == 8'h96, "R7", "plain restore", int'(rx_data), 8'h96);
        rx_wire_data = 8'h00;
        @(negedge clk);
        check(rx_data == 8'h96 && !rx_strobe, "R8", "hold after transfer",
              int'({rx_data, rx_strobe}), int'({8'h96, 1'b0}));
    endtask

    task automatic t_stream();
        logic [7:0] lfsr;
        apply_reset();
        for (int i = 0; i < 16; i++) begin
            send_byte(i[0] ? 8'hFF : 8'h00, "R4");
        end
        lfsr = 8'hB7;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            send_byte(lfsr ^ 8'(i * 37), "R4");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_example();
        t_threshold();
        t_flag_corner();
        t_idle_hold();
        t_decoder_direct();
        t_stream();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule